// File: doc/BRIEF.md
# MDIO Management Master with Host Register Front End

This block lets a host read and write the management registers of an Ethernet PHY over the two-wire MDC/MDIO bus. The host programs a small register set and then starts a transaction. A serial engine builds a clause-22 management frame, shifts it out on MDIO against a divided MDC clock, and for reads captures the 16 data bits the PHY returns.

Software sets the target PHY, the register number and the direction in the address register. For a write it also loads the write-data register. It then writes the control register with the enable bit and the go bit both set. The go bit reads back as 1 while the frame is in flight and drops to 0 when the frame ends. After a read, the read-data register holds the returned value. The MDIO pad is split into an output, an output enable and an input, so the tristate buffer can sit in the pad ring.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The host selects a register with `host_sel`: 0 is the address register, 1 is write data, 2 is read data and 3 is control. In the address register, bits 4:0 are the PHY register number, bits 9:5 are the PHY address, and bit 10 is the direction (1 read, 0 write). The address and write-data registers read back what was written.
- R2: The write-data register keeps bits 15:0 of a host write. The read-data register returns the 16 captured bits in bits 15:0 and reads 0 in bits 31:16.
- R3: Writing control bit 0 as 1 while enabled starts a frame. Control bit 0 reads 1 for exactly 64*2*CLK_HALF system clocks and then reads 0.
- R4: Control bit 3 is the enable bit and reads back as written. A go request written with bit 3 clear starts nothing: status stays 0 and MDC shows no edge.
- R5: A write frame is sent MSB first as: 32 ones, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then the 16 write-data bits. The master drives all 64 bits.
- R6: A read frame uses opcode 10. The master drives only the first 46 bits and releases MDIO from the turnaround on. It samples the 16 data bits on the rising MDC edges of bits 48 to 63 and stores them in the read-data register.
- R7: If no PHY answers and the line stays pulled high, a read returns 0xFFFF.
- R8: A go request while a frame is in flight has no effect. The running frame is unchanged and no second frame follows.
- R9: MDC has a period of 2*CLK_HALF system clocks while a frame runs and is held low when idle. MDIO changes only after a falling MDC edge.
- R10: After reset the status bit, enable bit, read data, MDC and MDIO output enable are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected register (combinational) |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench builds the block with CLK_HALF set to 2. A full 64-bit frame therefore lasts 256 system clocks, and the exact length of the busy window can be checked clock by clock. At this setting several complete frames, including one with a go request issued halfway through, fit in a short run. A PHY model on the resolved, pulled-up line captures every bit on rising MDC edges. When present, it drives turnaround and data from falling edges. It can also stay silent, which exercises the not-present result and catches any clash between the two drivers.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_BITS    = 64;
    localparam int PRE_BITS      = 32;
    localparam int RD_DRIVE_BITS = 46;
    localparam int DATA_FIRST    = 48;
    localparam int DATA_W        = 16;
    localparam int FIELD_W       = 5;
    localparam int ADDR_OP_BIT   = 10;
    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_EN_BIT   = 3;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_RDATA = 2'd2,
        SEL_CTRL  = 2'd3
    } host_sel_e;

    typedef struct packed {
        logic               is_read;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regad;
        logic [DATA_W-1:0]  wdata;
    } mdio_req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] dat;
        op  = r.is_read ? 2'b10 : 2'b01;
        ta  = r.is_read ? 2'b11 : 2'b10;
        dat = r.is_read ? {DATA_W{1'b1}} : r.wdata;
        return {{PRE_BITS{1'b1}}, 2'b01, op, r.phy, r.regad, ta, dat};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int CLK_HALF = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == CW'(CLK_HALF - 1));
    assign rise_tick = run && wrap && !mdc;
    assign fall_tick = run && wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);
    p_rise_needs_run_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> $past(run));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              mdio_i,
    input  logic              rise_tick,
    input  logic              fall_tick,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IW = $clog2(FRAME_BITS);

    logic [IW-1:0]         idx;
    logic [FRAME_BITS-1:0] sr;
    logic                  is_rd;
    logic [DATA_W-1:0]     rd_sr;
    logic                  last;

    assign last    = busy && fall_tick && (idx == IW'(FRAME_BITS - 1));
    assign mdio_o  = busy ? sr[FRAME_BITS-1] : 1'b0;
    assign mdio_oe = busy && (!is_rd || (idx < IW'(RD_DRIVE_BITS)));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx     <= '0;
            sr      <= '0;
            is_rd   <= 1'b0;
            rd_sr   <= '0;
            rd_data <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            idx   <= '0;
            sr    <= build_frame(req);
            is_rd <= req.is_read;
        end else if (busy) begin
            if (rise_tick && is_rd && (idx >= IW'(DATA_FIRST)))
                rd_sr <= {rd_sr[DATA_W-2:0], mdio_i};
            if (last) begin
                busy <= 1'b0;
                if (is_rd) rd_data <= rd_sr;
            end else if (fall_tick) begin
                idx <= idx + 1'b1;
                sr  <= {sr[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    p_frame_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !fall_tick) |=> $stable(sr));
    p_end_at_last_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(idx) == IW'(FRAME_BITS - 1)));
    p_rd_released_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && is_rd && rise_tick && (idx >= IW'(DATA_FIRST))) |-> !mdio_oe);
    p_ticks_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(rise_tick && fall_tick));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int CLK_HALF = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic [ADDR_OP_BIT:0] addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic                 en_q;
    logic                 busy;
    logic                 rise_tick;
    logic                 fall_tick;
    logic                 start;
    logic                 ctrl_wr;
    logic [DATA_W-1:0]    rd_data;
    mdio_req_t            req;
    host_sel_e            sel;

    assign sel     = host_sel_e'(host_sel);
    assign ctrl_wr = host_we && (sel == SEL_CTRL);
    assign start   = ctrl_wr && host_wdata[CTRL_GO_BIT] && host_wdata[CTRL_EN_BIT] && !busy;

    assign req.is_read = addr_q[ADDR_OP_BIT];
    assign req.phy     = addr_q[2*FIELD_W-1:FIELD_W];
    assign req.regad   = addr_q[FIELD_W-1:0];
    assign req.wdata   = wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            en_q    <= 1'b0;
        end else if (host_we) begin
            case (sel)
                SEL_ADDR:  addr_q  <= host_wdata[ADDR_OP_BIT:0];
                SEL_WDATA: wdata_q <= host_wdata[DATA_W-1:0];
                SEL_CTRL:  en_q    <= host_wdata[CTRL_EN_BIT];
                default:   ;
            endcase
        end
    end

    always_comb begin
        host_rdata = '0;
        case (sel)
            SEL_ADDR:  host_rdata[ADDR_OP_BIT:0] = addr_q;
            SEL_WDATA: host_rdata[DATA_W-1:0]    = wdata_q;
            SEL_RDATA: host_rdata[DATA_W-1:0]    = rd_data;
            SEL_CTRL: begin
                host_rdata[CTRL_GO_BIT] = busy;
                host_rdata[CTRL_EN_BIT] = en_q;
            end
            default: ;
        endcase
    end

    mdio_clk_div #(.CLK_HALF(CLK_HALF)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req       (req),
        .mdio_i    (mdio_i),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data)
    );

    p_gate_by_enable_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !host_wdata[CTRL_EN_BIT] && !busy) |=> !busy);
    p_idle_no_drive_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
    localparam int HALF = 2;
    localparam int FRAME_CLKS = 64 * 2 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdio_i, mdc, mdio_o, mdio_oe;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // PHY model on a pulled-up line
    logic        phy_present = 1'b0;
    logic [15:0] phy_data = '0;
    logic        phy_en = 1'b0;
    logic        phy_o = 1'b1;
    logic        cap [0:63];
    int          rises = 0;
    int          oe_viol = 0;
    int          clash = 0;

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_o : 1'b1);

    always #5 clk = ~clk;

    mdio_mgmt_master #(.CLK_HALF(HALF)) dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

    always @(posedge mdc) begin
        if (rises < 64) cap[rises] = mdio_i;
        if (rises >= 46 && cap[34] && !cap[35] && mdio_oe) oe_viol++;
        if (mdio_oe && phy_en) clash++;
        rises++;
    end

    always @(negedge mdc) begin
        if (phy_present && rises >= 47 && rises <= 63 && cap[34] && !cap[35]) begin
            phy_en = 1'b1;
            phy_o  = (rises == 47) ? 1'b0 : phy_data[63 - rises];
        end else begin
            phy_en = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] sel, output logic [31:0] d);
        host_sel = sel;
        #1;
        d = host_rdata;
    endtask

    task automatic run_frame(output int dur);
        logic [31:0] st;
        rises = 0; oe_viol = 0; clash = 0;
        host_write(2'd3, 32'h9);
        dur = 0;
        host_read(2'd3, st);
        while (st[0]) begin
            dur++;
            @(negedge clk);
            host_read(2'd3, st);
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                               input logic [4:0] ra, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
    endfunction

    function automatic int header_mismatch(input logic [63:0] f, input int nbits);
        int m = 0;
        for (int i = 0; i < nbits; i++) if (cap[i] !== f[63 - i]) m++;
        return m;
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        host_read(2'd3, v); check("R10 ctrl after reset", v, 32'h0);
        host_read(2'd2, v); check("R10 rdata after reset", v, 32'h0);
        check("R10 mdc/oe after reset", {30'b0, mdc, mdio_oe}, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        host_write(2'd0, 32'hFFFF_F000 | {21'b0, 1'b1, 5'h0A, 5'h15});
        host_read(2'd0, v); check("R1 address fields readback", v, {21'b0, 1'b1, 5'h0A, 5'h15});
        host_write(2'd1, 32'hDEAD_BEEF);
        host_read(2'd1, v); check("R2 wdata readback low 16", v, 32'h0000_BEEF);
    endtask

    task automatic t_enable_off;
        logic [31:0] v;
        rises = 0;
        host_write(2'd3, 32'h1);
        repeat (20) @(negedge clk);
        host_read(2'd3, v); check("R4 go without enable: status/enable", v, 32'h0);
        check("R4 go without enable: no mdc edge", rises, 0);
    endtask

    task automatic t_write;
        int dur;
        logic [31:0] v;
        host_write(2'd0, {21'b0, 1'b0, 5'h11, 5'h04});
        host_write(2'd1, 32'h0000_A5C3);
        run_frame(dur);
        check("R3 busy window length", dur, FRAME_CLKS);
        check("R9 mdc rising edges per frame", rises, 64);
        check("R5 write frame bits", header_mismatch(exp_frame(0, 5'h11, 5'h04, 16'hA5C3), 64), 0);
        host_read(2'd3, v); check("R4 enable bit reads back", v, 32'h8);
        check("R9 mdc idle low", mdc, 0);
    endtask

    task automatic t_read(input bit present, input logic [15:0] d, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [15:0] exp, input string tag);
        int dur;
        logic [31:0] v;
        phy_present = present; phy_data = d;
        host_write(2'd0, {21'b0, 1'b1, phy, ra});
        run_frame(dur);
        check({tag, " read header bits"}, header_mismatch(exp_frame(1, phy, ra, 16'h0), 46), 0);
        check("R6 master released after header", oe_viol, 0);
        check("R6 no driver clash", clash, 0);
        host_read(2'd2, v); check({tag, " read data"}, v, {16'h0, exp});
        phy_present = 1'b0;
    endtask

    task automatic t_go_while_busy;
        logic [31:0] st;
        rises = 0; oe_viol = 0; clash = 0;
        host_write(2'd0, {21'b0, 1'b0, 5'h03, 5'h1E});
        host_write(2'd1, 32'h0000_0F0F);
        host_write(2'd3, 32'h9);
        repeat (60) @(negedge clk);
        host_write(2'd0, {21'b0, 1'b1, 5'h1F, 5'h00});
        host_write(2'd3, 32'h9);
        repeat (FRAME_CLKS + 200) @(negedge clk);
        host_read(2'd3, st);
        check("R8 idle after single frame", st, 32'h8);
        check("R8 only one frame of mdc edges", rises, 64);
        check("R8 running frame unchanged", header_mismatch(exp_frame(0, 5'h03, 5'h1E, 16'h0F0F), 64), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regs;
        t_enable_off;
        t_write;
        t_read(1'b1, 16'h1234, 5'h01, 5'h02, 16'h1234, "R6");
        t_read(1'b1, 16'h8001, 5'h1F, 5'h1F, 16'h8001, "R6 edge pattern");
        t_read(1'b0, 16'h0000, 5'h07, 5'h01, 16'hFFFF, "R7");
        t_go_while_busy;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule